// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a low-power serial successive-approximation converter that returns 12-bit results. It opens a conversion by pulling an active-low select line down. It then waits a fixed setup time and runs a serial clock, derived from the system clock, for sixteen cycles. On every falling edge of that clock it captures the converter's data line. Each frame carries four zero bits and then the twelve result bits, most significant first.

When the frame ends, the select line goes high. In that same cycle the controller presents the result with a one-cycle valid strobe. A flag beside the result reports a framing fault if any of the four lead bits was not zero. Before the select line may fall again, a minimum idle gap must pass: a post-frame delay plus a quiet time. A single conversion is triggered with `start`. While `cont` is held high, conversions repeat at the spacing given on `period`. If `period` is shorter than one frame plus the idle gap, the spacing is stretched to that minimum. All timing quantities are counted in system clock cycles.

Top module: `sar_adc_reader`

## Requirements
- R1: After the synchronous reset `rst`, `cs_n` and `sclk` are 1, and `res_valid` and `busy` are 0.
- R2: A `start` or `cont` seen while idle pulls `cs_n` low at the next clock edge. The first falling edge of `sclk` comes SETUP_CYC + HALF_DIV cycles after `cs_n` falls, so `sclk` stays high through the setup interval.
- R3: Every frame contains exactly 16 falling edges of `sclk` while `cs_n` is low. Every low phase and every high phase between two falling edges lasts exactly HALF_DIV cycles, so no early clock cycle is shortened.
- R4: `sclk` is 1 in every cycle in which `cs_n` is 1.
- R5: `sdata` is captured at each falling edge of `sclk`. `res_data` holds the bits captured at falling edges 5 through 16, the first of them in bit 11.
- R6: `res_valid` is 1 for exactly one cycle per frame. That cycle is the first cycle with `cs_n` high again, which comes SETUP_CYC + 32*HALF_DIV cycles after `cs_n` fell.
- R7: `frame_err` is updated together with `res_data`. It is 1 exactly when any of the bits captured at falling edges 1 to 4 was 1.
- R8: Between two frames, `cs_n` stays high for at least POST_CYC + QUIET_CYC cycles.
- R9: With `cont` held at 1, consecutive falling edges of `cs_n` are max(`period`, SETUP_CYC + 32*HALF_DIV + POST_CYC + QUIET_CYC) cycles apart.
- R10: A `start` that arrives while `busy` is 1 has no effect. No extra frame follows.
- R11: If `cont` is 0 when the idle gap after a frame completes, the controller returns to idle (`busy` = 0) and starts no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one conversion |
| cont | input | 1 | Repeat conversions while high |
| period | input | PER_W | Spacing of conversions in continuous mode, in system cycles |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame or idle gap in progress |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | 12 | Conversion result |
| frame_err | output | 1 | A lead bit of the last frame was 1 |

## Verification
The bench sweeps result patterns and every value of the lead nibble. A capture that is off by one falling edge shows up as a shifted `res_data` and a wrong `frame_err`. A missing final edge shows up as a fifteen-edge frame.

Continuous mode is run with periods below, at and just above the minimum, and with longer ones. A controller that ignores the stretch rule, or that counts the period from the wrong edge, puts `cs_n` falls the wrong distance apart. The same runs catch a controller that cuts the quiet gap.

Start pulses are injected in the middle of a frame and during the gap, which exposes a controller that queues or restarts frames. Dropping `cont` right after a result exposes a controller that launches one frame too many.

// File: rtl/sar_adc_reader.sv
module sar_adc_reader #(
  parameter int unsigned HALF_DIV  = 2,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned POST_CYC  = 1,
  parameter int unsigned QUIET_CYC = 3,
  parameter int unsigned PER_W     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cont,
  input  logic [PER_W-1:0] period,
  input  logic             sdata,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic             res_valid,
  output logic [11:0]      res_data,
  output logic             frame_err
);

  localparam int CW = 16;
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HALF_LAST  = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'(POST_CYC + QUIET_CYC - 1);
  localparam logic [CW-1:0] GAP_LEN    = CW'(POST_CYC + QUIET_CYC);
  localparam logic [CW-1:0] HALF_LEN   = CW'(HALF_DIV);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SHIFT, S_GAP} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [4:0]     nfall;
  logic [15:0]    sh;
  logic [PER_W:0] pcnt;

  wire half_done = (cnt == HALF_LAST);
  wire gap_done  = (cnt >= GAP_LAST);
  wire per_done  = ({1'b0, period} <= pcnt + 1'b1);
  wire launch    = (st == S_IDLE && (start || cont)) ||
                   (st == S_GAP && gap_done && cont && per_done);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cs_n      <= 1'b1;
      sclk      <= 1'b1;
      cnt       <= '0;
      nfall     <= '0;
      sh        <= '0;
      pcnt      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      frame_err <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (!pcnt[PER_W]) pcnt <= pcnt + 1'b1;
      if (launch) begin
        st    <= S_SETUP;
        cs_n  <= 1'b0;
        cnt   <= '0;
        pcnt  <= '0;
        nfall <= '0;
      end else begin
        case (st)
          S_SETUP: begin
            if (cnt == SETUP_LAST) begin
              st  <= S_SHIFT;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_SHIFT: begin
            if (!half_done) cnt <= cnt + 1'b1;
            else begin
              cnt  <= '0;
              sclk <= ~sclk;
              if (sclk) begin
                sh    <= {sh[14:0], sdata};
                nfall <= nfall + 1'b1;
              end else if (nfall == 5'd16) begin
                st        <= S_GAP;
                cs_n      <= 1'b1;
                res_valid <= 1'b1;
                res_data  <= sh[11:0];
                frame_err <= |sh[15:12];
              end
            end
          end
          S_GAP: begin
            if (!gap_done) cnt <= cnt + 1'b1;
            else if (!cont) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic          cs_q, sclk_q, seen;
  logic [4:0]    fallcnt;
  logic [CW-1:0] lowcnt, hicnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      seen    <= 1'b0;
      fallcnt <= '0;
      lowcnt  <= '0;
      hicnt   <= '0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (!cs_n) seen <= 1'b1;
      if (cs_q && !cs_n) fallcnt <= '0;
      else if (sclk_q && !sclk) fallcnt <= fallcnt + 1'b1;
      lowcnt <= sclk ? '0 : lowcnt + 1'b1;
      if (!cs_n) hicnt <= '0;
      else if (hicnt != {CW{1'b1}}) hicnt <= hicnt + 1'b1;
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk); // R4
  AST_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && !cs_n) |-> lowcnt == HALF_LEN); // R3
  AST_FALLS_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> fallcnt == 5'd16); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R6
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $rose(cs_n)); // R6
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && seen) |-> hicnt >= GAP_LEN); // R8

endmodule

// File: tb/sim_sar_adc_reader.sv
`timescale 1ns/1ps
module sim_sar_adc_reader;
  localparam int HALF = 2, SETUP = 2, POST = 1, QUIET = 3, PW = 12;
  localparam int FRAME = SETUP + 32*HALF;
  localparam int GAPC  = POST + QUIET;
  localparam int MINP  = FRAME + GAPC;

  logic clk = 0, rst = 1, start = 0, cont = 0, sdata = 0;
  logic [PW-1:0] period = '0;
  wire cs_n, sclk, busy, res_valid, frame_err;
  wire [11:0] res_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] word = '0;
  int fidx = 0;

  sar_adc_reader #(.HALF_DIV(HALF), .SETUP_CYC(SETUP), .POST_CYC(POST),
                   .QUIET_CYC(QUIET), .PER_W(PW)) u0 (
    .clk(clk), .rst(rst), .start(start), .cont(cont), .period(period),
    .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .frame_err(frame_err));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge cs_n) begin
    fidx = 0;
    #1 sdata = word[15];
  end
  always @(negedge sclk) if (!cs_n) begin
    fidx = fidx + 1;
    #1 if (fidx < 16) sdata = word[15-fidx];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic pcs = 1, psclk = 1, pvalid = 0;
  int t_fall = 0, t_rise = 0, t_sfall = 0, t_srise = 0, nf = 0, frames = 0, exp_sp = 0;
  bit have_prev = 0;

  always @(negedge clk) if (!rst) begin
    if (cs_n) chk(sclk === 1'b1, "R4", sclk, 1);
    if (pcs && !cs_n) begin
      if (have_prev && exp_sp != 0) chk(cyc - t_fall == exp_sp, "R9", cyc - t_fall, exp_sp);
      if (have_prev) chk(cyc - t_rise >= GAPC, "R8", cyc - t_rise, GAPC);
      t_fall = cyc; nf = 0; have_prev = 1;
    end
    if (!pcs && cs_n) t_rise = cyc;
    if (!cs_n && psclk && !sclk) begin
      nf++;
      if (nf == 1) chk(cyc - t_fall == SETUP + HALF, "R2", cyc - t_fall, SETUP + HALF);
      else chk(cyc - t_srise == HALF, "R3", cyc - t_srise, HALF);
      t_sfall = cyc;
    end
    if (!cs_n && !psclk && sclk) begin
      chk(cyc - t_sfall == HALF, "R3", cyc - t_sfall, HALF);
      t_srise = cyc;
    end
    if (pvalid) chk(!res_valid, "R6", res_valid, 0);
    if (res_valid) begin
      frames++;
      chk(res_data == word[11:0], "R5", res_data, word[11:0]);
      chk(frame_err == |word[15:12], "R7", frame_err, |word[15:12]);
      chk(nf == 16, "R3", nf, 16);
      chk(cyc - t_fall == FRAME, "R6", cyc - t_fall, FRAME);
      chk(cs_n && !pcs, "R6", cs_n, 1);
    end
    if (!busy) have_prev = 0;
    pcs = cs_n; psclk = sclk; pvalid = res_valid;
  end

  task automatic wait_valid();
    int n = 0;
    @(negedge clk);
    while (!res_valid && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic single(input logic [15:0] w);
    word = w;
    start = 1; @(negedge clk); start = 0;
    wait_valid();
    wait_idle();
  endtask

  task automatic run_cont(input int p, input int n);
    int fsnap;
    period = PW'(p);
    exp_sp = (p > MINP) ? p : MINP;
    word = 16'h0A5C ^ 16'(p);
    word[15:12] = 4'h0;
    cont = 1;
    for (int k = 0; k < n; k++) wait_valid();
    cont = 0;
    @(negedge clk);
    fsnap = frames;
    repeat (GAPC + 2) @(negedge clk);
    chk(!busy, "R11", busy, 0);
    repeat (2*MINP) @(negedge clk);
    chk(frames == fsnap, "R11", frames, fsnap);
    exp_sp = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cs_n === 1 && sclk === 1 && res_valid === 0 && busy === 0, "R1",
        {cs_n, sclk, res_valid, busy}, 4'b1100);
    single(16'h0000);
    single(16'h0FFF);
    single(16'h0800);
    single(16'h0001);
    for (int v = 0; v < 64; v++) single({4'h0, 12'((v*1237 + 5) % 4096)});
    for (int n = 0; n < 16; n++) single({4'(n), 12'(n*273)});
    f0 = frames;
    word = 16'h0321;
    start = 1; @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_valid();
    start = 1; @(negedge clk); start = 0;
    wait_idle();
    repeat (100) @(negedge clk);
    chk(frames - f0 == 1, "R10", frames - f0, 1);
    run_cont(0, 4);
    run_cont(1, 4);
    run_cont(50, 4);
    run_cont(MINP - 1, 4);
    run_cont(MINP, 4);
    run_cont(MINP + 1, 4);
    run_cont(100, 4);
    run_cont(255, 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule